// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block holds the control and status register that a CPU uses to program its own flash. Software writes a command code into the register. A valid code arms a short window of a few clock cycles. Inside that window, a store strobe (or a load strobe, for the lock/fuse read command) carries out the armed command. If no strobe arrives in time, the command lapses and its bits clear by themselves.

There are five operations:
- a fill, which puts a 16-bit word into a temporary page buffer;
- a page erase;
- a page write, which streams the buffer out and then launches the flash operation;
- a buffer clear, bound to the section-read-enable code;
- a select that returns lock or fuse bits in place of program memory on a load.

Erase and write hold the CPU halted until the flash array reports completion over a start/done handshake. A ready interrupt is raised when the block is idle and interrupts are enabled.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00. Bits 6 and 5 of `reg_rdata` always read 0. Bit 7 is the interrupt enable, bit 4 is section read enable, bit 3 is lock select, bit 2 is page write, bit 1 is page erase and bit 0 is the programming enable.
- R2: A register write always updates bit 7. The low five bits take the written value only for the codes 5'b10001, 5'b01001, 5'b00101, 5'b00011 and 5'b00001; any other code leaves them unchanged. At most one of bits 4..1 is ever set, and a set command bit always has bit 0 set with it.
- R3: A valid code arms a window of 4 clock edges after the write edge. A store strobe sampled on any of those edges is accepted. If no strobe is accepted, the low five bits clear on the 4th edge.
- R4: With code 00001 armed, a store strobe writes `wdata` into buffer word `zaddr[5:1]`, ignores `zaddr[0]`, and clears bit 0.
- R5: With code 00011 armed, a store strobe starts an erase of page `zaddr[15:6]`. `fl_start` is a one-cycle pulse with `fl_erase`=1, `wdata` is ignored and no buffer words are streamed. `cpu_halt` stays high until `fl_done`, and then the low bits clear.
- R6: With code 00101 armed, a store strobe streams all 32 buffer words on `fl_wvalid`/`fl_widx`/`fl_wdata` in ascending index order. Unwritten words read 0xFFFF. The block then pulses `fl_start` with `fl_erase`=0 for page `zaddr[15:6]`. On `fl_done` all buffer words return to unwritten.
- R7: While `cpu_halt` is high, bit 0 and the active command bit stay set, and register writes leave bits 4..0 unchanged.
- R8: With code 01001 armed, a load strobe on one of the first 3 edges of the window raises `lock_rd` in that cycle, with `lock_fuse_sel` equal to `zaddr[0]`, and clears the low bits. On the 4th edge the load strobe is not honoured.
- R9: Writing code 10001 discards all buffer contents at once. A following store strobe inside the window clears the low bits.
- R10: `irq` is high when bit 7 and `gie` are set, bit 0 is clear, `ee_busy` is low and `cpu_halt` is low; otherwise it is low.
- R11: A store strobe with no command armed, or one that arrives after the window expired, changes neither the register nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| store_stb | input | 1 | Store-program-memory strobe |
| load_stb | input | 1 | Program-memory load strobe |
| zaddr | input | 16 | Z-pointer byte address |
| wdata | input | 16 | Data word for a fill |
| gie | input | 1 | Global interrupt enable |
| ee_busy | input | 1 | EEPROM write in progress |
| fl_done | input | 1 | Flash operation finished |
| fl_start | output | 1 | One-cycle flash operation start |
| fl_erase | output | 1 | 1 = erase, 0 = write, valid with `fl_start` |
| fl_page | output | 10 | Page number for the flash operation |
| fl_wvalid | output | 1 | Buffer word streaming out |
| fl_widx | output | 5 | Index of the streamed word |
| fl_wdata | output | 16 | Streamed word (0xFFFF if unwritten) |
| cpu_halt | output | 1 | CPU stall during erase/write |
| irq | output | 1 | Ready interrupt |
| lock_rd | output | 1 | Load returns lock/fuse bits this cycle |
| lock_fuse_sel | output | 1 | 0 = lock bits, 1 = fuse bits |

## Verification
Every 5-bit code is written from an idle register, with bits 6..5 forced high. This separates the five accepted codes from the 27 rejected ones and shows that the read-only bits stay zero. Fills are placed at strobe delays of 1 to 5 edges and at both values of `zaddr[0]`. Reading the buffer back through a page write then shows which delays fall inside the window and that the low Z bit does not steer the word index. Lock reads are also swept over delays of 1 to 4 edges with alternating Z bit 0. Back-to-back page writes, an erase, and a section-read-enable clear tell a buffer that keeps stale data apart from one that empties after a write.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    localparam int B_IE   = 7;
    localparam int B_RRE  = 4;
    localparam int B_LOCK = 3;
    localparam int B_PWR  = 2;
    localparam int B_PER  = 1;
    localparam int B_EN   = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_LAUNCH,
        ST_WAIT
    } op_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_FILL,
        CMD_ERASE,
        CMD_WRITE,
        CMD_LOCK,
        CMD_RRE
    } cmd_e;

    // Only five exact low-field codes arm a command.
    function automatic cmd_e decode_cmd(input logic [4:0] code);
        case (code)
            5'b00001: return CMD_FILL;
            5'b00011: return CMD_ERASE;
            5'b00101: return CMD_WRITE;
            5'b01001: return CMD_LOCK;
            5'b10001: return CMD_RRE;
            default:  return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/selfprog_page_buf.sv
module selfprog_page_buf #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [WORDS-1:0]  flags_d, flags_q;
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        flags_d = flags_q;
        if (clr) begin
            flags_d = '0;
        end else if (wr_en) begin
            flags_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Unwritten words present the erased-flash value.
    assign rd_data = flags_q[rd_idx] ? mem_q[rd_idx] : '1;

endmodule

// File: rtl/selfprog_cmd_fsm.sv
module selfprog_cmd_fsm
    import selfprog_pkg::*;
#(
    parameter int WORDS    = 32,
    parameter int ADDR_W   = 16,
    parameter int WIN      = 4,
    parameter int LOCK_WIN = 3,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int PAGE_W  = ADDR_W - IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              store_stb,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] zaddr,
    input  logic              gie,
    input  logic              ee_busy,
    input  logic              fl_done,
    output logic              buf_wr,
    output logic              buf_clr,
    output logic [IDX_W-1:0]  cpy_idx,
    output logic              fl_wvalid,
    output logic              fl_start,
    output logic              fl_erase,
    output logic [PAGE_W-1:0] fl_page,
    output logic              cpu_halt,
    output logic              irq,
    output logic              lock_rd,
    output logic              lock_fuse_sel
);

    localparam int CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_CNT  = CNT_W'(WIN);
    localparam logic [CNT_W-1:0] LOCK_MIN = CNT_W'(WIN - LOCK_WIN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic              ie;
        cmd_e              cmd;
        logic [CNT_W-1:0]  cnt;
        op_state_e         st;
        logic [IDX_W-1:0]  cpy;
        logic [PAGE_W-1:0] page;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cmd_e new_cmd;
    logic armed;
    logic used;

    always_comb begin
        ctl_d     = ctl_q;
        buf_wr    = 1'b0;
        buf_clr   = 1'b0;
        fl_wvalid = 1'b0;
        fl_start  = 1'b0;
        used      = 1'b0;
        new_cmd   = decode_cmd(reg_wdata[4:0]);
        armed     = (ctl_q.cmd != CMD_NONE) && (ctl_q.st == ST_IDLE);
        lock_rd   = load_stb && armed && (ctl_q.cmd == CMD_LOCK) && (ctl_q.cnt >= LOCK_MIN);

        case (ctl_q.st)
            ST_IDLE: begin
                if (armed) begin
                    if (lock_rd) begin
                        ctl_d.cmd = CMD_NONE;
                        used      = 1'b1;
                    end else if (store_stb) begin
                        case (ctl_q.cmd)
                            CMD_FILL: begin
                                buf_wr    = 1'b1;
                                ctl_d.cmd = CMD_NONE;
                                used      = 1'b1;
                            end
                            CMD_RRE: begin
                                ctl_d.cmd = CMD_NONE;
                                used      = 1'b1;
                            end
                            CMD_ERASE: begin
                                ctl_d.page = zaddr[ADDR_W-1:IDX_W+1];
                                ctl_d.st   = ST_LAUNCH;
                                used       = 1'b1;
                            end
                            CMD_WRITE: begin
                                ctl_d.page = zaddr[ADDR_W-1:IDX_W+1];
                                ctl_d.st   = ST_COPY;
                                ctl_d.cpy  = '0;
                                used       = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    if (used) begin
                        ctl_d.cnt = '0;
                    end else if (ctl_q.cnt <= CNT_W'(1)) begin
                        ctl_d.cmd = CMD_NONE;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                    end
                end
                if (reg_we && (new_cmd != CMD_NONE) && !used) begin
                    ctl_d.cmd = new_cmd;
                    ctl_d.cnt = WIN_CNT;
                    buf_clr   = (new_cmd == CMD_RRE);
                end
            end
            ST_COPY: begin
                fl_wvalid = 1'b1;
                if (ctl_q.cpy == LAST_IDX) begin
                    ctl_d.st = ST_LAUNCH;
                end else begin
                    ctl_d.cpy = ctl_q.cpy + IDX_W'(1);
                end
            end
            ST_LAUNCH: begin
                fl_start = 1'b1;
                ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (fl_done) begin
                    buf_clr   = (ctl_q.cmd == CMD_WRITE);
                    ctl_d.cmd = CMD_NONE;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (reg_we) begin
            ctl_d.ie = reg_wdata[B_IE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ie: 1'b0, cmd: CMD_NONE, cnt: '0, st: ST_IDLE, cpy: '0, page: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_IE]   = ctl_q.ie;
        reg_rdata[B_RRE]  = (ctl_q.cmd == CMD_RRE);
        reg_rdata[B_LOCK] = (ctl_q.cmd == CMD_LOCK);
        reg_rdata[B_PWR]  = (ctl_q.cmd == CMD_WRITE);
        reg_rdata[B_PER]  = (ctl_q.cmd == CMD_ERASE);
        reg_rdata[B_EN]   = (ctl_q.cmd != CMD_NONE);
    end

    assign cpy_idx       = ctl_q.cpy;
    assign fl_page       = ctl_q.page;
    assign fl_erase      = (ctl_q.cmd == CMD_ERASE);
    assign cpu_halt      = (ctl_q.st != ST_IDLE);
    assign lock_fuse_sel = zaddr[0];
    assign irq           = ctl_q.ie && gie && (ctl_q.cmd == CMD_NONE) && !ee_busy && !cpu_halt;

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl #(
    parameter int WORDS    = 32,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int WIN      = 4,
    parameter int LOCK_WIN = 3,
    localparam int IDX_W   = $clog2(WORDS),
    localparam int PAGE_W  = ADDR_W - IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              store_stb,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] zaddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gie,
    input  logic              ee_busy,
    input  logic              fl_done,
    output logic              fl_start,
    output logic              fl_erase,
    output logic [PAGE_W-1:0] fl_page,
    output logic              fl_wvalid,
    output logic [IDX_W-1:0]  fl_widx,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              cpu_halt,
    output logic              irq,
    output logic              lock_rd,
    output logic              lock_fuse_sel
);

    logic             buf_wr;
    logic             buf_clr;
    logic [IDX_W-1:0] cpy_idx;

    selfprog_cmd_fsm #(
        .WORDS    (WORDS),
        .ADDR_W   (ADDR_W),
        .WIN      (WIN),
        .LOCK_WIN (LOCK_WIN)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .store_stb     (store_stb),
        .load_stb      (load_stb),
        .zaddr         (zaddr),
        .gie           (gie),
        .ee_busy       (ee_busy),
        .fl_done       (fl_done),
        .buf_wr        (buf_wr),
        .buf_clr       (buf_clr),
        .cpy_idx       (cpy_idx),
        .fl_wvalid     (fl_wvalid),
        .fl_start      (fl_start),
        .fl_erase      (fl_erase),
        .fl_page       (fl_page),
        .cpu_halt      (cpu_halt),
        .irq           (irq),
        .lock_rd       (lock_rd),
        .lock_fuse_sel (lock_fuse_sel)
    );

    selfprog_page_buf #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_idx  (zaddr[IDX_W:1]),
        .wr_data (wdata),
        .clr     (buf_clr),
        .rd_idx  (cpy_idx),
        .rd_data (fl_wdata)
    );

    assign fl_widx = cpy_idx;

endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int WIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ee_busy,
    input logic       cpu_halt,
    input logic       fl_start,
    input logic       irq
);

    int unsigned armed_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_run <= 0;
        end else if (reg_we || !reg_rdata[0] || cpu_halt) begin
            armed_run <= 0;
        end else begin
            armed_run <= armed_run + 1;
        end
    end

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:5] == 2'b00);

    p_single_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(reg_rdata[4:1]) <= 1);

    p_cmd_has_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_rdata[4:1]) |-> reg_rdata[0]);

    p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (selfprog_pkg::decode_cmd(reg_wdata[4:0]) == selfprog_pkg::CMD_NONE)
         && (reg_rdata[4:0] == 5'b0) && !cpu_halt) |=> (reg_rdata[4:0] == 5'b0));

    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_run <= WIN);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |=> !fl_start);

    p_start_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |-> cpu_halt);

    p_halt_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> reg_rdata[0]);

    p_halt_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && $past(cpu_halt)) |-> $stable(reg_rdata[4:0]));

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy || cpu_halt || reg_rdata[0]) |-> !irq);

endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.WIN(WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ee_busy   (ee_busy),
    .cpu_halt  (cpu_halt),
    .fl_start  (fl_start),
    .irq       (irq)
);

// File: tb/tb_selfprog_ctrl.sv
module tb_selfprog_ctrl;

    localparam int WORDS  = 32;
    localparam int IDX_W  = 5;
    localparam int PAGE_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        store_stb = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] zaddr = '0;
    logic [15:0] wdata = '0;
    logic        gie = 1'b0;
    logic        ee_busy = 1'b0;
    logic        fl_done = 1'b0;
    logic        fl_start, fl_erase, fl_wvalid, cpu_halt, irq, lock_rd, lock_fuse_sel;
    logic [PAGE_W-1:0] fl_page;
    logic [IDX_W-1:0]  fl_widx;
    logic [15:0]       fl_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] exp_mem [WORDS];

    always #4 clk = ~clk;

    selfprog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .store_stb(store_stb), .load_stb(load_stb),
        .zaddr(zaddr), .wdata(wdata), .gie(gie), .ee_busy(ee_busy),
        .fl_done(fl_done), .fl_start(fl_start), .fl_erase(fl_erase),
        .fl_page(fl_page), .fl_wvalid(fl_wvalid), .fl_widx(fl_widx),
        .fl_wdata(fl_wdata), .cpu_halt(cpu_halt), .irq(irq),
        .lock_rd(lock_rd), .lock_fuse_sel(lock_fuse_sel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic csr_wr(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic spm(input logic [15:0] z, input logic [15:0] d);
        store_stb = 1'b1;
        zaddr = z;
        wdata = d;
        tick();
        store_stb = 1'b0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 16'hFFFF;
    endtask

    task automatic finish_op(input logic [4:0] code);
        tick();
        csr_wr(8'h01);
        chk(reg_rdata[4:0] == code, "R7 bits held while halted", reg_rdata[4:0], code);
        chk(cpu_halt && !irq, "R10 irq quiet while halted", {cpu_halt, irq}, 2'b10);
        fl_done = 1'b1;
        tick();
        fl_done = 1'b0;
        chk(reg_rdata[4:0] == 5'h00, "R5 bits clear on done", reg_rdata[4:0], 0);
        chk(!cpu_halt, "R5 halt released", cpu_halt, 0);
    endtask

    task automatic do_write(input logic [15:0] z);
        logic [15:0] got [WORDS];
        int seen = 0;
        bit started = 1'b0;
        csr_wr(8'h85);
        spm(z, 16'hDEAD);
        for (int n = 0; n < 100 && !started; n++) begin
            if (fl_wvalid) begin
                if (fl_widx != IDX_W'(seen))
                    chk(0, "R6 stream order", fl_widx, seen);
                got[fl_widx] = fl_wdata;
                seen++;
            end
            if (!cpu_halt || !reg_rdata[0])
                chk(0, "R7 halt and enable during copy", {cpu_halt, reg_rdata[0]}, 2'b11);
            if (fl_start) started = 1'b1;
            else tick();
        end
        chk(started && !fl_erase, "R6 write launched", {started, fl_erase}, 2'b10);
        chk(seen == WORDS, "R6 word count", seen, WORDS);
        chk(fl_page == z[15:6], "R6 page number", fl_page, z[15:6]);
        for (int i = 0; i < WORDS; i++)
            chk(got[i] == exp_mem[i], $sformatf("R6 word %0d (R4 R11 R9)", i), got[i], exp_mem[i]);
        finish_op(5'h05);
        clear_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog requirement all actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
        chk(!cpu_halt && !fl_start && !irq, "R1 reset outputs", {cpu_halt, fl_start, irq}, 0);

        // R2 sweep of every low-field code
        for (int v = 0; v < 32; v++) begin
            logic [4:0] c = 5'(v);
            logic [7:0] exp;
            bit ok = (c == 5'h11) || (c == 5'h09) || (c == 5'h05) || (c == 5'h03) || (c == 5'h01);
            exp = {c[0], 2'b00, ok ? c : 5'h00};
            csr_wr({c[0], 2'b11, c});
            chk(reg_rdata == exp, $sformatf("R2 R1 code %0h", c), reg_rdata, exp);
            repeat (5) tick();
        end
        csr_wr(8'h00);

        // R3 timeout on the 4th edge
        csr_wr(8'h01);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk(reg_rdata[0] == (k < 4), $sformatf("R3 enable after edge %0d", k), reg_rdata[0], k < 4);
        end

        // R3 R4 R11 strobe delays 1..5, word k, Z0 alternating
        for (int k = 1; k <= 5; k++) begin
            logic [15:0] d = 16'hA000 + 16'(k);
            csr_wr(8'h01);
            repeat (k - 1) tick();
            spm({10'h155, 5'(k), 1'(k)}, d);
            if (k <= 4) exp_mem[k] = d;
            chk(reg_rdata[4:0] == 5'h00, $sformatf("R4 R11 bits after delay %0d", k), reg_rdata[4:0], 0);
            repeat (2) tick();
        end
        spm({10'h0, 5'd6, 1'b0}, 16'h1234);
        chk(reg_rdata == 8'h00, "R11 stray strobe", reg_rdata, 0);

        // R4 fill sweep
        for (int i = 8; i < WORDS; i++) begin
            if (i % 3 != 2) begin
                logic [15:0] d = (16'(i) * 16'h0101) ^ 16'h5A00;
                csr_wr(8'h01);
                spm({10'h3FF, 5'(i), ~1'(i)}, d);
                exp_mem[i] = d;
            end
        end
        do_write(16'b0000001011_101010);
        do_write(16'b1100000001_000001);

        // R5 erase
        begin
            bit streamed = 1'b0;
            bit started = 1'b0;
            csr_wr(8'h03);
            chk(reg_rdata[4:0] == 5'h03, "R5 erase armed", reg_rdata[4:0], 5'h03);
            spm(16'b1010100101_110011, 16'h7777);
            for (int n = 0; n < 20 && !started; n++) begin
                if (fl_wvalid) streamed = 1'b1;
                if (fl_start) started = 1'b1;
                else tick();
            end
            chk(started && fl_erase && !streamed, "R5 erase launch", {started, fl_erase, streamed}, 3'b110);
            chk(fl_page == 10'b1010100101, "R5 erase page", fl_page, 10'b1010100101);
            finish_op(5'h03);
        end

        // R9 section read enable discards the buffer
        csr_wr(8'h01);
        spm({10'h0, 5'd3, 1'b0}, 16'h3333);
        csr_wr(8'h01);
        spm({10'h0, 5'd20, 1'b1}, 16'h2020);
        csr_wr(8'h11);
        chk(reg_rdata[4:0] == 5'h11, "R9 armed", reg_rdata[4:0], 5'h11);
        spm(16'h0, 16'h0);
        chk(reg_rdata[4:0] == 5'h00, "R9 strobe clears", reg_rdata[4:0], 0);
        do_write(16'h0040);

        // R8 lock/fuse read window
        for (int k = 1; k <= 4; k++) begin
            bit z0 = 1'(k);
            csr_wr(8'h09);
            repeat (k - 1) tick();
            load_stb = 1'b1;
            zaddr = {15'h0, z0};
            #1;
            chk(lock_rd == (k <= 3), $sformatf("R8 lock_rd delay %0d", k), lock_rd, k <= 3);
            if (k <= 3)
                chk(lock_fuse_sel == z0, "R8 fuse select", lock_fuse_sel, z0);
            tick();
            load_stb = 1'b0;
            chk(reg_rdata[4:0] == 5'h00, "R8 bits cleared", reg_rdata[4:0], 0);
            repeat (2) tick();
        end

        // R10 ready interrupt
        csr_wr(8'h80);
        gie = 1'b1;
        #1 chk(irq == 1'b1, "R10 irq on", irq, 1);
        ee_busy = 1'b1;
        #1 chk(irq == 1'b0, "R10 ee_busy masks", irq, 0);
        ee_busy = 1'b0;
        gie = 1'b0;
        #1 chk(irq == 1'b0, "R10 gie masks", irq, 0);
        gie = 1'b1;
        tick();
        csr_wr(8'h81);
        chk(irq == 1'b0, "R10 enable masks", irq, 0);
        repeat (4) tick();
        chk(irq == 1'b1, "R10 irq after timeout", irq, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule